// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block connects the waveform generator of an 8-bit timer to one general-purpose I/O pin. It holds an internal compare-output flip-flop, modelled as a two-state machine (`OC_LOW`, `OC_HIGH`). Each compare-match pulse changes that state according to a 2-bit action field. In non-PWM operation a one-cycle force strobe applies the same action without a match. The compare state is kept apart from the pin, so software can set it to a known level while the pin driver is still disabled, and then enable the pin.

A multiplexer at the output picks the pin's data source. When the action field is nonzero, the compare state drives the pin; otherwise the I/O port data bit does. The pin driver enable always comes from the data-direction bit. The action field is not buffered: the value on `com_i` in the cycle of an event is the value that is used.

The state machine has four named transitions. From `OC_LOW`, `T_RISE_TOGGLE` (toggle action) and `T_RISE_SET` (set action) go to `OC_HIGH`. From `OC_HIGH`, `T_FALL_TOGGLE` (toggle action) and `T_FALL_CLEAR` (clear action) go to `OC_LOW`. In every other case the state holds.

Top module: `oc_pin_unit`

## Requirements
- R1: While `rst_n` is low, the compare state is 0 (`oc_state_o`=0). When the action field is 00, `pin_o` equals `port_bit_i`.
- R2: With the action field `com_i`=00, a compare match leaves the compare state unchanged.
- R3: With `com_i`=01 (toggle), a compare match inverts the compare state on the next clock edge.
- R4: With `com_i`=10 (clear), a match makes the state 0. With `com_i`=11 (set), a match makes the state 1. Both take effect on the next clock edge.
- R5: The action applied at a match is the `com_i` value present in that match cycle. A value written just before the match applies there, with no buffering delay.
- R6: When `pwm_mode_i`=0, a one-cycle `force_i` pulse applies the `com_i` action on the next clock edge with no compare match.
- R7: When `pwm_mode_i`=1, `force_i` has no effect on the compare state, and compare matches still apply the `com_i` action.
- R8: When `com_i` is nonzero, `pin_o` equals the compare state; when `com_i`=00, `pin_o` equals `port_bit_i`. The selection is the same for both values of `pwm_mode_i`.
- R9: `pin_oe_o` always equals `ddr_bit_i`, including while the compare state drives `pin_o`.
- R10: The compare state can be preset with `ddr_bit_i`=0 (driver off). Setting `ddr_bit_i`=1 afterwards shows the preset level on `pin_o` with `pin_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_i | input | 1 | Compare-match pulse from the timer |
| pwm_mode_i | input | 1 | 1 = PWM operation, 0 = non-PWM operation |
| com_i | input | 2 | Action field: 00 none, 01 toggle, 10 clear, 11 set |
| force_i | input | 1 | Force strobe, honoured in non-PWM operation only |
| port_bit_i | input | 1 | I/O port data bit |
| ddr_bit_i | input | 1 | Data-direction bit (1 = output) |
| pin_o | output | 1 | Pin output data |
| pin_oe_o | output | 1 | Pin driver enable |
| oc_state_o | output | 1 | Internal compare-output state |

## Verification
The assertions check the following on every cycle:
- The pin source selection and the driver enable.
- That the state holds whenever no event occurs, including a force strobe in PWM operation.
- The result of each toggle, clear and set event on the following cycle.

The bench scenarios are needed for the rest:
- The reset value.
- That a field value written just before a match applies at that match.
- A preset with the driver off that becomes visible once the direction bit is set.
- Long toggle sequences checked against an independent model.

// File: rtl/oc_pin_pkg.sv
package oc_pin_pkg;
    localparam int COM_W = 2;

    typedef enum logic [COM_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_action_e;

    typedef enum logic {
        OC_LOW  = 1'b0,
        OC_HIGH = 1'b1
    } oc_state_e;
endpackage

// File: rtl/oc_event_gen.sv
module oc_event_gen
    import oc_pin_pkg::*;
(
    input  logic             match_i,
    input  logic             force_i,
    input  logic             pwm_mode_i,
    input  logic [COM_W-1:0] com_i,
    output logic             fire_o,
    output oc_action_e       action_o
);
    // a force strobe only counts outside PWM operation
    always_comb begin
        fire_o   = match_i | (force_i & ~pwm_mode_i);
        action_o = oc_action_e'(com_i);
    end
endmodule

// File: rtl/oc_state_fsm.sv
module oc_state_fsm
    import oc_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  oc_action_e action_i,
    output logic       oc_o
);
    oc_state_e cur_q;
    oc_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= OC_LOW;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        if (fire_i) begin
            unique case (cur_q)
                OC_LOW: begin
                    // T_RISE_TOGGLE, T_RISE_SET
                    if (action_i == ACT_TOGGLE || action_i == ACT_SET)
                        nxt = OC_HIGH;
                end
                OC_HIGH: begin
                    // T_FALL_TOGGLE, T_FALL_CLEAR
                    if (action_i == ACT_TOGGLE || action_i == ACT_CLEAR)
                        nxt = OC_LOW;
                end
            endcase
        end
    end

    always_comb begin
        oc_o = (cur_q == OC_HIGH);
    end
endmodule

// File: rtl/oc_pin_mux.sv
module oc_pin_mux
    import oc_pin_pkg::*;
(
    input  logic [COM_W-1:0] com_i,
    input  logic             oc_i,
    input  logic             port_bit_i,
    input  logic             ddr_bit_i,
    output logic             pin_o,
    output logic             pin_oe_o
);
    logic override;

    always_comb begin
        override = |com_i;
        pin_o    = override ? oc_i : port_bit_i;
        pin_oe_o = ddr_bit_i;
    end
endmodule

// File: rtl/oc_pin_unit.sv
module oc_pin_unit
    import oc_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match_i,
    input  logic             pwm_mode_i,
    input  logic [COM_W-1:0] com_i,
    input  logic             force_i,
    input  logic             port_bit_i,
    input  logic             ddr_bit_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             oc_state_o
);
    logic       fire;
    oc_action_e action;
    logic       oc;

    oc_event_gen u_evt (
        .match_i    (match_i),
        .force_i    (force_i),
        .pwm_mode_i (pwm_mode_i),
        .com_i      (com_i),
        .fire_o     (fire),
        .action_o   (action)
    );

    oc_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .action_i (action),
        .oc_o     (oc)
    );

    oc_pin_mux u_mux (
        .com_i      (com_i),
        .oc_i       (oc),
        .port_bit_i (port_bit_i),
        .ddr_bit_i  (ddr_bit_i),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe_o)
    );

    assign oc_state_o = oc;
endmodule

// File: rtl/oc_pin_unit_chk.sv
module oc_pin_unit_chk
    import oc_pin_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             match_i,
    input logic             pwm_mode_i,
    input logic [COM_W-1:0] com_i,
    input logic             force_i,
    input logic             port_bit_i,
    input logic             ddr_bit_i,
    input logic             pin_o,
    input logic             pin_oe_o,
    input logic             oc_state_o
);
    a_r2_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (com_i == 2'b00) |=> $stable(oc_state_o));

    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && com_i == 2'b01) |=> (oc_state_o != $past(oc_state_o)));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && com_i == 2'b10) |=> !oc_state_o);

    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && com_i == 2'b11) |=> oc_state_o);

    a_r6_force_acts: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i && !pwm_mode_i && com_i == 2'b11) |=> oc_state_o);

    a_r7_pwm_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_i && (pwm_mode_i || !force_i)) |=> $stable(oc_state_o));

    a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
        (com_i != 2'b00) |-> (pin_o == oc_state_o));

    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (com_i == 2'b00) |-> (pin_o == port_bit_i));

    a_r9_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o == ddr_bit_i);
endmodule

bind oc_pin_unit oc_pin_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_i    (match_i),
    .pwm_mode_i (pwm_mode_i),
    .com_i      (com_i),
    .force_i    (force_i),
    .port_bit_i (port_bit_i),
    .ddr_bit_i  (ddr_bit_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .oc_state_o (oc_state_o)
);

// File: tb/oc_pin_unit_tb_top.sv
module oc_pin_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       match_i = 1'b0;
    logic       pwm_mode_i = 1'b0;
    logic [1:0] com_i = 2'b00;
    logic       force_i = 1'b0;
    logic       port_bit_i = 1'b0;
    logic       ddr_bit_i = 1'b0;
    logic       pin_o, pin_oe_o, oc_state_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  pin;
        logic  oe;
        logic  oc;
        string req;
    } exp_t;

    exp_t sb_q[$];
    logic model_oc = 1'b0;

    always #5 clk = ~clk;

    oc_pin_unit dut_i (
        .clk(clk), .rst_n(rst_n), .match_i(match_i), .pwm_mode_i(pwm_mode_i),
        .com_i(com_i), .force_i(force_i), .port_bit_i(port_bit_i),
        .ddr_bit_i(ddr_bit_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
        .oc_state_o(oc_state_o)
    );

    function automatic logic ref_next(logic cur, logic m, logic f, logic p, logic [1:0] c);
        if (!(m || (f && !p))) return cur;
        case (c)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    // drive one cycle at the falling edge and queue what should appear after the next rise
    task automatic step(logic m, logic f, logic p, logic [1:0] c,
                        logic pb, logic dd, string req);
        exp_t e;
        @(negedge clk);
        match_i = m; force_i = f; pwm_mode_i = p; com_i = c;
        port_bit_i = pb; ddr_bit_i = dd;
        model_oc = ref_next(model_oc, m, f, p, c);
        e.oc  = model_oc;
        e.pin = (c != 2'b00) ? model_oc : pb;
        e.oe  = dd;
        e.req = req;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (pin_o !== e.pin || pin_oe_o !== e.oe || oc_state_o !== e.oc) begin
                errors++;
                $display("FAIL %s pin/oe/oc actual %b%b%b expected %b%b%b",
                         e.req, pin_o, pin_oe_o, oc_state_o, e.pin, e.oe, e.oc);
            end
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset value and passthrough while held in reset
        port_bit_i = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (oc_state_o !== 1'b0 || pin_o !== 1'b1) begin
            errors++;
            $display("FAIL R1 oc/pin actual %b%b expected 01", oc_state_o, pin_o);
        end
        @(negedge clk); rst_n = 1'b1;

        step(0, 0, 0, 2'b00, 1, 1, "R1");
        step(0, 0, 0, 2'b00, 0, 1, "R8");
        // R2 no action
        step(1, 0, 0, 2'b00, 0, 1, "R2");
        step(1, 0, 0, 2'b00, 1, 0, "R2");
        // R3 toggles
        for (int i = 0; i < 5; i++) step(1, 0, 0, 2'b01, 0, 1, "R3");
        step(0, 0, 0, 2'b01, 1, 1, "R3");
        // R4 set and clear
        step(1, 0, 0, 2'b11, 0, 1, "R4");
        step(1, 0, 0, 2'b11, 0, 1, "R4");
        step(1, 0, 0, 2'b10, 1, 1, "R4");
        step(1, 0, 0, 2'b10, 1, 1, "R4");
        // R5 field changed in the match cycle itself
        step(0, 0, 0, 2'b10, 0, 1, "R5");
        step(1, 0, 0, 2'b11, 0, 1, "R5");
        step(0, 0, 0, 2'b01, 0, 1, "R5");
        step(1, 0, 0, 2'b01, 0, 1, "R5");
        // R6 force without match
        step(0, 1, 0, 2'b11, 0, 1, "R6");
        step(0, 1, 0, 2'b01, 0, 1, "R6");
        step(0, 0, 0, 2'b01, 0, 1, "R6");
        // R7 force ignored in PWM, matches still act
        step(0, 1, 1, 2'b11, 0, 1, "R7");
        step(0, 1, 1, 2'b01, 0, 1, "R7");
        step(1, 0, 1, 2'b01, 0, 1, "R7");
        step(1, 1, 1, 2'b01, 0, 1, "R7");
        // R8 override the same in PWM
        step(0, 0, 1, 2'b00, 1, 1, "R8");
        step(0, 0, 1, 2'b10, 0, 1, "R8");
        // R9 enable follows direction under override
        step(0, 0, 0, 2'b11, 0, 0, "R9");
        step(0, 0, 0, 2'b11, 0, 1, "R9");
        // R10 preset with driver off, then enable
        step(0, 1, 0, 2'b10, 1, 0, "R10");
        step(0, 1, 0, 2'b11, 0, 0, "R10");
        step(0, 0, 0, 2'b11, 0, 0, "R10");
        step(0, 0, 0, 2'b11, 0, 1, "R10");
        step(0, 0, 0, 2'b00, 0, 1, "R10");
        step(0, 0, 0, 2'b00, 0, 1, "R1");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule